// File: doc/BRIEF.md
# Dithered One-Bit Phase Detector Loop

This block is the digital phase detector of a fractional-N synthesizer. A programmable divider counts cycles of the fast oscillator clock. A first-order sigma-delta accumulator turns a fractional word into occasional extra counts, so the average divide ratio can fall between integers. On each rising edge of the reference clock, a single flip-flop samples the divided clock and yields one bit. That bit tells only whether the divided clock leads or lags. The jitter that the sigma-delta sequence adds to the divided edge dithers this coarse quantizer.

An inner loop keeps the two clocks close together. The phase bit is brought into the oscillator domain through a two-stage synchronizer and then nudges the next divide value up or down by a programmable gain. Feeding phase back into a frequency control integrates, so the divided edge stays within about one step of the reference edge.

A first-order IIR low-pass filter averages the bit stream into a signed phase-error word for the outer loop filter. Its average is proportional to the phase difference as long as the error stays small against the dither.

The divider is a two-state machine. In state DV_HIGH the divided clock is high. Its transition DV_HIGH→DV_LOW fires when the count reaches half the period. In state DV_LOW the divided clock is low. Its transition DV_LOW→DV_HIGH fires at the last count of the period; on that transition the next divide value is loaded and the accumulator advances. Reset forces DV_HIGH.

Top module: `pdl_phase_loop`

## Requirements
- R1: While `rst` is high at an edge of its domain, the block returns to its reset state. In that state `div_clk` is 1 (state DV_HIGH, count 0), `phase_bit` is 0, `phase_word` is 0, the accumulator and both synchronizer stages are 0, and the loaded divide value is `int_word` clamped to the range 4..255.
- R2: At each rising edge of `clk_ref`, `phase_bit` takes the level of `div_clk`. A 1 means the divided rising edge has already occurred in the current divided period, so the divided clock leads.
- R3: A divided period of D oscillator cycles holds `div_clk` high for floor(D/2) cycles and then low for D − floor(D/2) cycles.
- R4: At the last cycle of each period, the next D is `int_word` + carry + `loop_gain` if the synchronized bit is 1, or `int_word` + carry − `loop_gain` if it is 0. The synchronized bit is `phase_bit` after two `clk_osc` flops, taken at its value before that edge.
- R5: The 8-bit accumulator adds `frac_word` once per period, at the period's last cycle. The carry used for that period's reload is 1 when the sum reaches 256, and the sum is kept modulo 256.
- R6: Every divide value the R4 rule would put below 4 becomes 4, and every value above 255 becomes 255.
- R7: At each `clk_ref` rising edge, `phase_word` y becomes y + ((x − y) >>> k). Here x is +16384 if `phase_bit` held 1 before that edge and −16384 if it held 0. k is `filt_shift` clamped to the range 2..8.
- R8: When the reference period equals the nominal divided period (`int_word` + `frac_word`/256 oscillator cycles) and `loop_gain` is 1, the long-run mean of `phase_bit` lies within 2% of one half.
- R9: With gain 1, a reference period longer than nominal drives the mean `phase_word` positive, and a shorter one drives it negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Fast oscillator clock that drives the divider |
| clk_ref | input | 1 | Reference clock; its rising edge samples the divided clock |
| rst | input | 1 | Synchronous reset, active high, seen in both clock domains |
| int_word | input | 8 | Integer part of the divide ratio |
| frac_word | input | 8 | Fractional part of the divide ratio, in units of 1/256 |
| loop_gain | input | 4 | Inner-loop step added to or removed from the divide value |
| filt_shift | input | 4 | Filter shift k, clamped to 2..8 |
| div_clk | output | 1 | Divided clock, high during the first half of each period |
| phase_bit | output | 1 | Raw one-bit phase sample |
| phase_word | output | 16 | Signed filtered phase-error word |

## Verification
Two events can fall in the same oscillator cycle. One is the reload of the divide value at the end of a period. The other is a change in the synchronized phase bit, which reaches the divider through the second flop exactly when the reload takes place. When the loop is locked, the reference edge sits right beside the divided rising edge, so the bit flips near almost every reload; the locked runs therefore produce this coincidence again and again. A behavioural model in the bench uses the synchronizer value from before the edge and is compared with `div_clk` in every oscillator cycle. This makes any off-by-one in the order of reload and synchronizer update show up as a diverging waveform.

// File: rtl/pdl_pkg.sv
`timescale 1ns/1ps
package pdl_pkg;

    typedef enum logic {
        DV_HIGH = 1'b0,
        DV_LOW  = 1'b1
    } dv_state_e;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/pdl_sync2.sv
`timescale 1ns/1ps
module pdl_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pdl_sd_accum.sv
`timescale 1ns/1ps
module pdl_sd_accum #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (step) acc_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/pdl_div_fsm.sv
`timescale 1ns/1ps
module pdl_div_fsm
    import pdl_pkg::*;
#(
    parameter int INT_W   = 8,
    parameter int GAIN_W  = 4,
    parameter int CNT_W   = 8,
    parameter int DIV_MIN = 4,
    parameter int DIV_MAX = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  int_word,
    input  logic              carry,
    input  logic              lead,
    input  logic [GAIN_W-1:0] gain,
    output logic              div_clk,
    output logic              period_end,
    output logic [CNT_W-1:0]  div_len
);
    dv_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, len_d, half;
    logic              last_hi, last_cyc;
    int                raw;

    assign half     = div_len >> 1;
    assign last_hi  = (cnt_q == half - 1'b1);
    assign last_cyc = (cnt_q == div_len - 1'b1);

    always_comb begin
        raw     = int'(int_word) + int'(carry) + (lead ? int'(gain) : -int'(gain));
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        len_d   = div_len;
        unique case (state_q)
            DV_HIGH: begin
                if (last_hi) state_d = DV_LOW;
            end
            DV_LOW: begin
                if (last_cyc) begin
                    state_d = DV_HIGH;
                    cnt_d   = '0;
                    len_d   = CNT_W'(clamp_int(raw, DIV_MIN, DIV_MAX));
                end
            end
            default: begin
                state_d = DV_HIGH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DV_HIGH;
            cnt_q   <= '0;
            div_len <= CNT_W'(clamp_int(int'(int_word), DIV_MIN, DIV_MAX));
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            div_len <= len_d;
        end
    end

    always_comb begin
        div_clk    = (state_q == DV_HIGH);
        period_end = (state_q == DV_LOW) && last_cyc;
    end
endmodule

// File: rtl/pdl_phase_filter.sv
`timescale 1ns/1ps
module pdl_phase_filter
    import pdl_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SHIFT_W = 4,
    parameter int SH_MIN  = 2,
    parameter int SH_MAX  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     div_clk,
    input  logic [SHIFT_W-1:0]       shift,
    output logic                     phase_bit,
    output logic signed [WORD_W-1:0] phase_word
);
    localparam int AMP   = 2 ** (WORD_W - 2);
    localparam int EXT_W = WORD_W + 2;

    logic signed [EXT_W-1:0]  target, diff, delta;
    logic signed [WORD_W-1:0] word_d;
    int                       k;

    always_comb begin
        k      = clamp_int(int'(shift), SH_MIN, SH_MAX);
        target = phase_bit ? EXT_W'(AMP) : -EXT_W'(AMP);
        diff   = target - EXT_W'(phase_word);
        delta  = diff >>> k;
        word_d = phase_word + delta[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_bit  <= 1'b0;
            phase_word <= '0;
        end else begin
            phase_bit  <= div_clk;
            phase_word <= word_d;
        end
    end
endmodule

// File: rtl/pdl_phase_loop.sv
`timescale 1ns/1ps
module pdl_phase_loop
    import pdl_pkg::*;
#(
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 8,
    parameter int GAIN_W      = 4,
    parameter int SHIFT_W     = 4,
    parameter int WORD_W      = 16,
    parameter int DIV_MIN     = 4,
    parameter int DIV_MAX     = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk_osc,
    input  logic                     clk_ref,
    input  logic                     rst,
    input  logic [INT_W-1:0]         int_word,
    input  logic [FRAC_W-1:0]        frac_word,
    input  logic [GAIN_W-1:0]        loop_gain,
    input  logic [SHIFT_W-1:0]       filt_shift,
    output logic                     div_clk,
    output logic                     phase_bit,
    output logic signed [WORD_W-1:0] phase_word
);
    localparam int CNT_W = $clog2(DIV_MAX + 1);

    logic             carry;
    logic             period_end;
    logic             lead_sync;
    logic [CNT_W-1:0] div_len;

    pdl_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_osc),
        .rst (rst),
        .d   (phase_bit),
        .q   (lead_sync)
    );

    pdl_sd_accum #(.FRAC_W(FRAC_W)) u_sd (
        .clk   (clk_osc),
        .rst   (rst),
        .step  (period_end),
        .frac  (frac_word),
        .carry (carry)
    );

    pdl_div_fsm #(
        .INT_W   (INT_W),
        .GAIN_W  (GAIN_W),
        .CNT_W   (CNT_W),
        .DIV_MIN (DIV_MIN),
        .DIV_MAX (DIV_MAX)
    ) u_div (
        .clk        (clk_osc),
        .rst        (rst),
        .int_word   (int_word),
        .carry      (carry),
        .lead       (lead_sync),
        .gain       (loop_gain),
        .div_clk    (div_clk),
        .period_end (period_end),
        .div_len    (div_len)
    );

    pdl_phase_filter #(
        .WORD_W  (WORD_W),
        .SHIFT_W (SHIFT_W)
    ) u_filt (
        .clk        (clk_ref),
        .rst        (rst),
        .div_clk    (div_clk),
        .shift      (filt_shift),
        .phase_bit  (phase_bit),
        .phase_word (phase_word)
    );
endmodule

// File: rtl/pdl_phase_loop_chk.sv
`timescale 1ns/1ps
module pdl_phase_loop_chk #(
    parameter int CNT_W   = 8,
    parameter int WORD_W  = 16,
    parameter int DIV_MIN = 4
) (
    input logic                     clk_osc,
    input logic                     clk_ref,
    input logic                     rst,
    input logic                     div_clk,
    input logic                     phase_bit,
    input logic signed [WORD_W-1:0] phase_word,
    input logic [CNT_W-1:0]         div_len
);
    localparam int AMP = 2 ** (WORD_W - 2);

    logic [CNT_W-1:0] hi_cnt;

    always_ff @(posedge clk_osc) begin
        if (rst)          hi_cnt <= '0;
        else if (div_clk) hi_cnt <= hi_cnt + 1'b1;
        else              hi_cnt <= '0;
    end

    // R3: the high phase lasts half the loaded period
    a_r3_high_len: assert property (@(posedge clk_osc) disable iff (rst)
        $fell(div_clk) |-> (hi_cnt == (div_len >> 1)));

    // R6: the loaded divide value never drops below the floor
    a_r6_len_floor: assert property (@(posedge clk_osc) disable iff (rst)
        int'(div_len) >= DIV_MIN);

    // R2: the phase bit is the divided level seen at the previous reference edge
    a_r2_bit_sample: assert property (@(posedge clk_ref) disable iff (rst)
        !$past(rst) |-> (phase_bit == $past(div_clk)));

    // R7: the filter output stays inside the input amplitude
    a_r7_word_bound: assert property (@(posedge clk_ref) disable iff (rst)
        (int'(phase_word) <= AMP) && (int'(phase_word) >= -AMP));
endmodule

bind pdl_phase_loop pdl_phase_loop_chk #(
    .CNT_W   (CNT_W),
    .WORD_W  (WORD_W),
    .DIV_MIN (DIV_MIN)
) u_chk (
    .clk_osc    (clk_osc),
    .clk_ref    (clk_ref),
    .rst        (rst),
    .div_clk    (div_clk),
    .phase_bit  (phase_bit),
    .phase_word (phase_word),
    .div_len    (div_len)
);

// File: tb/pdl_phase_loop_test.sv
`timescale 1ns/1ps
module pdl_phase_loop_test;
    localparam realtime OSC_PERIOD = 10.0;

    logic        clk_osc = 1'b0;
    logic        clk_ref = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  int_word = 8'd21;
    logic [7:0]  frac_word = 8'd0;
    logic [3:0]  loop_gain = 4'd0;
    logic [3:0]  filt_shift = 4'd4;
    logic        div_clk;
    logic        phase_bit;
    logic signed [15:0] phase_word;

    realtime ref_period = 210.0;
    int    n_cmp = 0, n_bad = 0;
    bit    chk_on = 0, meas_on = 0, done = 0;
    string osc_tag = "R3";
    int    ones = 0, nsamp = 0;
    longint wsum = 0;
    int    since_rise = 0, last_period = 0, hi_run = 0, last_hi = 0;
    bit    prev_div = 0;

    int m_cnt = 0, m_len = 21, m_acc = 0, m_s1 = 0, m_s2 = 0, m_pbit = 0, m_y = 0;

    pdl_phase_loop uut (
        .clk_osc    (clk_osc),
        .clk_ref    (clk_ref),
        .rst        (rst),
        .int_word   (int_word),
        .frac_word  (frac_word),
        .loop_gain  (loop_gain),
        .filt_shift (filt_shift),
        .div_clk    (div_clk),
        .phase_bit  (phase_bit),
        .phase_word (phase_word)
    );

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int m_div();
        return (m_cnt < m_len / 2) ? 1 : 0;
    endfunction

    task automatic check(string req, bit ok, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    initial forever #(OSC_PERIOD / 2) clk_osc = ~clk_osc;

    initial begin
        #0.5;
        forever begin
            clk_ref = 1'b1;
            #(ref_period / 2);
            clk_ref = 1'b0;
            #(ref_period / 2);
        end
    end

    // reference model, oscillator domain
    always @(posedge clk_osc) begin
        if (rst) begin
            m_cnt = 0;
            m_len = clampi(int'(int_word), 4, 255);
            m_acc = 0;
            m_s1  = 0;
            m_s2  = 0;
        end else begin
            if (m_cnt == m_len - 1) begin
                int s, c;
                s     = m_acc + int'(frac_word);
                c     = (s >= 256) ? 1 : 0;
                m_acc = s % 256;
                m_len = clampi(int'(int_word) + c + (m_s2 != 0 ? int'(loop_gain) : -int'(loop_gain)), 4, 255);
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            m_s2 = m_s1;
            m_s1 = m_pbit;
        end
    end

    // reference model, reference domain
    always @(posedge clk_ref) begin
        if (rst) begin
            m_pbit = 0;
            m_y    = 0;
        end else begin
            int x, k;
            x      = (m_pbit != 0) ? 16384 : -16384;
            k      = clampi(int'(filt_shift), 2, 8);
            m_y    = m_y + ((x - m_y) >>> k);
            m_pbit = m_div();
        end
    end

    always @(posedge clk_osc) begin
        #2;
        if (chk_on) check(osc_tag, div_clk == m_div()[0], div_clk, m_div());
        since_rise++;
        if (div_clk) hi_run++;
        if (div_clk && !prev_div) begin
            last_period = since_rise;
            since_rise  = 0;
        end
        if (!div_clk && prev_div) begin
            last_hi = hi_run;
            hi_run  = 0;
        end
        prev_div = div_clk;
    end

    always @(posedge clk_ref) begin
        #1;
        if (chk_on) begin
            check("R2", phase_bit == m_pbit[0], phase_bit, m_pbit);
            check("R7", int'(phase_word) == m_y, phase_word, m_y);
        end
        if (meas_on) begin
            ones  += int'(phase_bit);
            wsum  += longint'(phase_word);
            nsamp++;
        end
    end

    task automatic wait_ref(int n);
        repeat (n) @(posedge clk_ref);
        #3;
    endtask

    task automatic measure(int settle, int n);
        wait_ref(settle);
        ones = 0; nsamp = 0; wsum = 0;
        meas_on = 1;
        wait_ref(n);
        meas_on = 0;
    endtask

    initial begin
        #3 chk_on = 1;
        #900;
        check("R1", div_clk == 1'b1, div_clk, 1);
        check("R1", phase_bit == 1'b0, phase_bit, 0);
        check("R1", phase_word == 16'sd0, phase_word, 0);
        #100 rst = 1'b0;

        // open loop, whole period, R3
        osc_tag = "R3";
        wait_ref(25);
        check("R3", last_period == 21, last_period, 21);
        check("R3", last_hi == 10, last_hi, 10);

        // nominal reference, fractional divide, R5 and R8
        osc_tag = "R5";
        int_word = 8'd20; frac_word = 8'd128; loop_gain = 4'd1;
        ref_period = 205.0;
        measure(200, 1600);
        check("R8", ones >= 768 && ones <= 832, ones, 800);

        // slower reference, R4 and R9
        osc_tag = "R4";
        ref_period = 207.0;
        measure(300, 1500);
        check("R9", (wsum / nsamp) > 1000, wsum / nsamp, 3277);

        // faster reference, R9
        ref_period = 203.0;
        measure(300, 1500);
        check("R9", (wsum / nsamp) < -1000, wsum / nsamp, -3277);

        // low clamp and shift floor, R6 and R7
        osc_tag = "R6";
        ref_period = 205.0;
        int_word = 8'd2; frac_word = 8'd0; loop_gain = 4'd1; filt_shift = 4'd0;
        wait_ref(30);
        check("R6", last_period == 4, last_period, 4);

        // high clamp and shift ceiling, R6 and R7
        int_word = 8'd255; frac_word = 8'd255; loop_gain = 4'd15; filt_shift = 4'd12;
        ref_period = 2551.0;
        wait_ref(40);
        check("R6", last_period == 255 || last_period == 240 || last_period == 241,
              last_period, 241);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_osc);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule